// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This control unit sits next to a small processor core and carries out the hardware part of entering and leaving an interrupt handler. While the sequencer is idle it samples an instruction-boundary strobe. When a request is accepted there, it latches a snapshot of the core's program counter, status word and two general registers. It writes these four words to a stack in memory, reads the handler address from a vector table, and hands the core a new program counter together with a status word whose global enable bit is cleared. A return strobe reads the four words back in reverse order and gives the core all of them to restore.

There are two request lines. A maskable request carries a 3-bit source index and is taken only while the enable bit of the snapshot status is set. A non-maskable request is taken whatever that bit says and always uses source index 7. Reset is a separate path that touches no memory. Once reset is released, the sequencer tells the core to load a fixed start address and zeroed registers, and this entry has no return. The core must stall while `busy` is high.

Top module: `irq_seq`

## Requirements
- R1: After reset is released, `pc_load` and `regs_load` pulse together for one cycle with `new_pc` = 0x0100 and `new_st`, `new_r0`, `new_r1` all zero, and no memory access takes place. `busy` is high while reset is held.
- R2: A request is accepted only in a cycle where the sequencer is idle and `insn_done` is high. Without `insn_done`, requests cause no memory access and leave `busy` low.
- R3: A maskable request is ignored while bit 0 (the global enable) of `snap_st` is 0.
- R4: A non-maskable request is accepted whatever bit 0 of `snap_st` holds, and it takes priority over a maskable request in the same cycle. It uses vector index 7.
- R5: After acceptance, the sequencer makes four writes in consecutive cycles. The first comes in the cycle after acceptance. The stack pointer is decremented by 2 before each write, so the addresses are SP-2, SP-4, SP-6 and SP-8, and the data are the captured PC, status, R0 and R1 in that order. The stack pointer starts at 0x0200.
- R6: In the cycle after the last write, one read is made at address 0x0040 + 2*index. Two cycles after that read, `pc_load` pulses with `new_pc` equal to the word that was read.
- R7: On an interrupt entry, `new_st` is the captured status with bit 0 cleared, and `regs_load` stays low.
- R8: When the sequencer is idle, `rti_strobe` starts four reads from SP, SP+2, SP+4 and SP+6, returning R1, R0, status and PC in that order. Two cycles after the last read, `pc_load` and `regs_load` pulse together with the restored values, including the restored enable bit. The stack pointer ends at its value from before the entry.
- R9: `busy` rises in the cycle after acceptance and falls in the cycle in which the load pulse appears. It is low whenever the sequencer is idle.
- R10: If `rti_strobe` and an acceptable request arrive in the same cycle, the return runs and the request is not taken.
- R11: Nested entries stack below one another, each one 8 bytes lower, and their returns unwind in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Instruction boundary strobe |
| irq_req | input | 1 | Maskable request |
| irq_idx | input | 3 | Source index of the maskable request |
| nmi_req | input | 1 | Non-maskable request |
| rti_strobe | input | 1 | Return-from-interrupt strobe |
| snap_pc | input | 16 | Core program counter snapshot |
| snap_st | input | 16 | Core status word snapshot, bit 0 = global enable |
| snap_r0 | input | 16 | General register 0 snapshot |
| snap_r1 | input | 16 | General register 1 snapshot |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable (0 = read) |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| busy | output | 1 | Core stall |
| pc_load | output | 1 | Load PC and status from `new_pc`/`new_st` |
| regs_load | output | 1 | Load R0 and R1 from `new_r0`/`new_r1` |
| new_pc | output | 16 | Program counter to load |
| new_st | output | 16 | Status word to load |
| new_r0 | output | 16 | R0 value to load |
| new_r1 | output | 16 | R1 value to load |

## Verification
The bench walks every source index through a complete entry and return and checks each write address and data word. A design that got the pointer wrong would write at SP instead of SP-2, or store the words in the wrong order. It also corrupts the round trip, so that restored registers would come back swapped. Masked requests, requests without a boundary strobe and non-maskable requests with the enable off are each tried, so a design that tests the enable for both request kinds, or neither, shows up at once. Nested entries followed by a return that collides with a pending request show whether the pointer unwinds correctly and whether the return keeps its priority. A design that got this wrong would push the request instead of popping the frame.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [2:0] {
        ST_RST  = 3'd0,
        ST_IDLE = 3'd1,
        ST_PUSH = 3'd2,
        ST_VRD  = 3'd3,
        ST_VLD  = 3'd4,
        ST_POP  = 3'd5,
        ST_PEND = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RTI  = 2'd1,
        ACC_NMI  = 2'd2,
        ACC_IRQ  = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/irq_seq_accept.sv
module irq_seq_accept
    import irq_seq_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             idle,
    input  logic             insn_done,
    input  logic             irq_req,
    input  logic [IDX_W-1:0] irq_idx,
    input  logic             nmi_req,
    input  logic             rti_strobe,
    input  logic             ie,
    output acc_kind_e        kind,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] NMI_IDX = '1;

    always_comb begin
        kind = ACC_NONE;
        idx  = irq_idx;
        if (idle) begin
            // a return is an instruction of its own and wins over requests
            if (rti_strobe) begin
                kind = ACC_RTI;
            end else if (insn_done && nmi_req) begin
                kind = ACC_NMI;
                idx  = NMI_IDX;
            end else if (insn_done && irq_req && ie) begin
                kind = ACC_IRQ;
            end
        end
    end

endmodule

// File: rtl/irq_seq_memport.sv
module irq_seq_memport
    import irq_seq_pkg::*;
#(
    parameter int              W        = 16,
    parameter int              IDX_W    = 3,
    parameter logic [W-1:0]    VEC_BASE = 16'h0040
) (
    input  seq_state_e       state,
    input  logic [1:0]       cnt,
    input  logic [W-1:0]     sp,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     sav_pc,
    input  logic [W-1:0]     sav_st,
    input  logic [W-1:0]     sav_r0,
    input  logic [W-1:0]     sav_r1,
    output logic             req,
    output logic             we,
    output logic [W-1:0]     addr,
    output logic [W-1:0]     wdata
);
    localparam logic [W-1:0] WORD_BYTES = W'(2);

    always_comb begin
        req   = 1'b0;
        we    = 1'b0;
        addr  = sp;
        wdata = sav_pc;
        case (state)
            ST_PUSH: begin
                req  = 1'b1;
                we   = 1'b1;
                addr = sp - WORD_BYTES;
                case (cnt)
                    2'd0:    wdata = sav_pc;
                    2'd1:    wdata = sav_st;
                    2'd2:    wdata = sav_r0;
                    default: wdata = sav_r1;
                endcase
            end
            ST_VRD: begin
                req  = 1'b1;
                addr = VEC_BASE + W'({idx, 1'b0});
            end
            ST_POP: begin
                req  = 1'b1;
                addr = sp;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int           W        = 16,
    parameter int           IDX_W    = 3,
    parameter int           IE_BIT   = 0,
    parameter logic [W-1:0] VEC_BASE = 16'h0040,
    parameter logic [W-1:0] RESET_PC = 16'h0100,
    parameter logic [W-1:0] SP_TOP   = 16'h0200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_done,
    input  logic             irq_req,
    input  logic [IDX_W-1:0] irq_idx,
    input  logic             nmi_req,
    input  logic             rti_strobe,
    input  logic [W-1:0]     snap_pc,
    input  logic [W-1:0]     snap_st,
    input  logic [W-1:0]     snap_r0,
    input  logic [W-1:0]     snap_r1,
    output logic             mem_req,
    output logic             mem_we,
    output logic [W-1:0]     mem_addr,
    output logic [W-1:0]     mem_wdata,
    input  logic [W-1:0]     mem_rdata,
    output logic             busy,
    output logic             pc_load,
    output logic             regs_load,
    output logic [W-1:0]     new_pc,
    output logic [W-1:0]     new_st,
    output logic [W-1:0]     new_r0,
    output logic [W-1:0]     new_r1
);
    localparam logic [W-1:0] IE_MASK    = W'(1) << IE_BIT;
    localparam logic [W-1:0] WORD_BYTES = W'(2);
    localparam logic [1:0]   LAST_WORD  = 2'd3;

    typedef struct packed {
        seq_state_e       st;
        logic [1:0]       cnt;
        logic [W-1:0]     sp;
        logic [IDX_W-1:0] idx;
        logic [W-1:0]     pc;
        logic [W-1:0]     stw;
        logic [W-1:0]     r0;
        logic [W-1:0]     r1;
        logic             pc_load;
        logic             regs_load;
        logic [W-1:0]     o_pc;
        logic [W-1:0]     o_st;
        logic [W-1:0]     o_r0;
        logic [W-1:0]     o_r1;
    } seq_t;

    seq_t q, d;

    acc_kind_e        acc_kind;
    logic [IDX_W-1:0] acc_idx;

    irq_seq_accept #(.IDX_W(IDX_W)) u_accept (
        .idle       (q.st == ST_IDLE),
        .insn_done  (insn_done),
        .irq_req    (irq_req),
        .irq_idx    (irq_idx),
        .nmi_req    (nmi_req),
        .rti_strobe (rti_strobe),
        .ie         (snap_st[IE_BIT]),
        .kind       (acc_kind),
        .idx        (acc_idx)
    );

    irq_seq_memport #(.W(W), .IDX_W(IDX_W), .VEC_BASE(VEC_BASE)) u_memport (
        .state  (q.st),
        .cnt    (q.cnt),
        .sp     (q.sp),
        .idx    (q.idx),
        .sav_pc (q.pc),
        .sav_st (q.stw),
        .sav_r0 (q.r0),
        .sav_r1 (q.r1),
        .req    (mem_req),
        .we     (mem_we),
        .addr   (mem_addr),
        .wdata  (mem_wdata)
    );

    always_comb begin
        d           = q;
        d.pc_load   = 1'b0;
        d.regs_load = 1'b0;
        case (q.st)
            ST_RST: begin
                // entry without stacking: fixed start, cleared registers
                d.pc_load   = 1'b1;
                d.regs_load = 1'b1;
                d.o_pc      = RESET_PC;
                d.o_st      = '0;
                d.o_r0      = '0;
                d.o_r1      = '0;
                d.st        = ST_IDLE;
            end
            ST_IDLE: begin
                d.cnt = 2'd0;
                case (acc_kind)
                    ACC_RTI: d.st = ST_POP;
                    ACC_NMI, ACC_IRQ: begin
                        d.st  = ST_PUSH;
                        d.idx = acc_idx;
                        d.pc  = snap_pc;
                        d.stw = snap_st;
                        d.r0  = snap_r0;
                        d.r1  = snap_r1;
                    end
                    default: ;
                endcase
            end
            ST_PUSH: begin
                d.sp  = q.sp - WORD_BYTES;
                d.cnt = q.cnt + 2'd1;
                if (q.cnt == LAST_WORD) d.st = ST_VRD;
            end
            ST_VRD: d.st = ST_VLD;
            ST_VLD: begin
                d.pc_load = 1'b1;
                d.o_pc    = mem_rdata;
                d.o_st    = q.stw & ~IE_MASK;
                d.st      = ST_IDLE;
            end
            ST_POP: begin
                d.sp  = q.sp + WORD_BYTES;
                d.cnt = q.cnt + 2'd1;
                // read data lags its request by one cycle
                case (q.cnt)
                    2'd1: d.r1 = mem_rdata;
                    2'd2: d.r0 = mem_rdata;
                    2'd3: d.stw = mem_rdata;
                    default: ;
                endcase
                if (q.cnt == LAST_WORD) d.st = ST_PEND;
            end
            ST_PEND: begin
                d.pc_load   = 1'b1;
                d.regs_load = 1'b1;
                d.o_pc      = mem_rdata;
                d.o_st      = q.stw;
                d.o_r0      = q.r0;
                d.o_r1      = q.r1;
                d.st        = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_RST;
            q.sp <= SP_TOP;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign pc_load   = q.pc_load;
    assign regs_load = q.regs_load;
    assign new_pc    = q.o_pc;
    assign new_st    = q.o_st;
    assign new_r0    = q.o_r0;
    assign new_r1    = q.o_r1;

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
    parameter int W      = 16,
    parameter int IE_BIT = 0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         insn_done,
    input logic         nmi_req,
    input logic         irq_req,
    input logic         rti_strobe,
    input logic [W-1:0] snap_st,
    input logic         mem_req,
    input logic         mem_we,
    input logic [W-1:0] mem_addr,
    input logic         pc_load,
    input logic         regs_load,
    input logic [W-1:0] new_st
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);  // R2

    AST_NO_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !insn_done && !rti_strobe) |=> !busy);  // R2

    AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !nmi_req && !rti_strobe && !snap_st[IE_BIT]) |=> !busy);  // R3

    AST_NMI_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && insn_done && nmi_req && !rti_strobe) |=> (busy && mem_we));  // R4

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - W'(2)));  // R5

    AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_req && busy));  // R5

    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load);  // R6

    AST_ENTRY_IE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !regs_load) |-> !new_st[IE_BIT]);  // R7

    AST_LOAD_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> !busy);  // R9

    AST_RTI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rti_strobe) |=> (busy && mem_req && !mem_we));  // R10

endmodule

bind irq_seq irq_seq_chk #(.W(W), .IE_BIT(IE_BIT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .insn_done  (insn_done),
    .nmi_req    (nmi_req),
    .irq_req    (irq_req),
    .rti_strobe (rti_strobe),
    .snap_st    (snap_st),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .pc_load    (pc_load),
    .regs_load  (regs_load),
    .new_st     (new_st)
);

// File: tb/tb_irq_seq.sv
module tb_irq_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_done = 1'b0, irq_req = 1'b0, nmi_req = 1'b0, rti_strobe = 1'b0;
    logic [2:0]  irq_idx = '0;
    logic [15:0] snap_pc = '0, snap_st = '0, snap_r0 = '0, snap_r1 = '0;
    logic        mem_req, mem_we, busy, pc_load, regs_load;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, new_pc, new_st, new_r0, new_r1;

    int checks = 0;
    int errors = 0;
    logic [15:0] sp_m = 16'h0200;
    logic [15:0] mem [0:255];
    logic [15:0] rd_q = '0;

    always #4 clk = ~clk;

    irq_seq dut (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .irq_req(irq_req),
        .irq_idx(irq_idx), .nmi_req(nmi_req), .rti_strobe(rti_strobe),
        .snap_pc(snap_pc), .snap_st(snap_st), .snap_r0(snap_r0), .snap_r1(snap_r1),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .pc_load(pc_load), .regs_load(regs_load),
        .new_pc(new_pc), .new_st(new_st), .new_r0(new_r0), .new_r1(new_r1)
    );

    assign mem_rdata = rd_q;

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;
            else        rd_q <= mem[mem_addr[8:1]];
        end
    end

    function automatic logic [15:0] vec_val(input int i);
        return 16'h4000 + 16'(i) * 16'h0123;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_entry(input logic use_nmi, input logic use_irq, input logic [2:0] idx,
                            input logic [15:0] pc, input logic [15:0] st,
                            input logic [15:0] r0, input logic [15:0] r1,
                            input logic [2:0] exp_idx);
        logic [15:0] exp_w [4];
        exp_w[0] = pc; exp_w[1] = st; exp_w[2] = r0; exp_w[3] = r1;
        @(negedge clk);
        insn_done = 1'b1; nmi_req = use_nmi; irq_req = use_irq; irq_idx = idx;
        snap_pc = pc; snap_st = st; snap_r0 = r0; snap_r1 = r1;
        @(negedge clk);
        insn_done = 1'b0; nmi_req = 1'b0; irq_req = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", 16'(busy), 16'd1);
        for (int k = 0; k < 4; k++) begin
            if (k > 0) @(negedge clk);
            chk(mem_req && mem_we, "R5 push write", {14'd0, mem_req, mem_we}, 16'd3);
            chk(mem_addr == sp_m - 16'(2 * (k + 1)), "R5 push addr", mem_addr, sp_m - 16'(2 * (k + 1)));
            chk(mem_wdata == exp_w[k], "R5 push data", mem_wdata, exp_w[k]);
        end
        sp_m = sp_m - 16'd8;
        @(negedge clk);
        chk(mem_req && !mem_we, "R6 vector read", {14'd0, mem_req, mem_we}, 16'd2);
        chk(mem_addr == 16'h0040 + 16'(2 * exp_idx), "R6 vector addr", mem_addr, 16'h0040 + 16'(2 * exp_idx));
        @(negedge clk);
        chk(busy && !pc_load, "R9 busy before load", {14'd0, busy, pc_load}, 16'd2);
        @(negedge clk);
        chk(pc_load && !regs_load, "R7 entry load strobes", {14'd0, pc_load, regs_load}, 16'd2);
        chk(new_pc == vec_val(int'(exp_idx)), "R6 handler pc", new_pc, vec_val(int'(exp_idx)));
        chk(new_st == (st & 16'hFFFE), "R7 entry status", new_st, st & 16'hFFFE);
        chk(!busy, "R9 busy low at load", 16'(busy), 16'd0);
    endtask

    task automatic do_return(input logic [15:0] pc, input logic [15:0] st,
                             input logic [15:0] r0, input logic [15:0] r1, input logic with_irq);
        @(negedge clk);
        rti_strobe = 1'b1;
        if (with_irq) begin
            insn_done = 1'b1; irq_req = 1'b1; snap_st = 16'h0001; irq_idx = 3'd5;
        end
        @(negedge clk);
        rti_strobe = 1'b0; insn_done = 1'b0; irq_req = 1'b0;
        chk(mem_req && !mem_we, with_irq ? "R10 return wins" : "R8 pop read",
            {14'd0, mem_req, mem_we}, 16'd2);
        for (int k = 0; k < 4; k++) begin
            if (k > 0) @(negedge clk);
            chk(mem_addr == sp_m + 16'(2 * k) && !mem_we, "R8 pop addr", mem_addr, sp_m + 16'(2 * k));
        end
        sp_m = sp_m + 16'd8;
        @(negedge clk);
        chk(busy && !pc_load, "R9 busy before restore", {14'd0, busy, pc_load}, 16'd2);
        @(negedge clk);
        chk(pc_load && regs_load, "R8 restore strobes", {14'd0, pc_load, regs_load}, 16'd3);
        chk(new_pc == pc, "R8 restored pc", new_pc, pc);
        chk(new_st == st, "R8 restored status", new_st, st);
        chk(new_r0 == r0, "R8 restored r0", new_r0, r0);
        chk(new_r1 == r1, "R8 restored r1", new_r1, r1);
        chk(!busy, "R9 busy low after restore", 16'(busy), 16'd0);
    endtask

    task automatic hold_ignored(input logic ins, input logic irq, input logic nmi,
                                input logic [15:0] st, input string req);
        @(negedge clk);
        insn_done = ins; irq_req = irq; nmi_req = nmi; snap_st = st;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(!busy && !mem_req, req, {14'd0, busy, mem_req}, 16'd0);
        end
        insn_done = 1'b0; irq_req = 1'b0; nmi_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        for (int i = 0; i < 8; i++) mem[8'h20 + i] = vec_val(i);
        repeat (3) @(negedge clk);
        chk(busy && !mem_req, "R1 held in reset", {14'd0, busy, mem_req}, 16'd2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pc_load && regs_load, "R1 reset load strobes", {14'd0, pc_load, regs_load}, 16'd3);
        chk(new_pc == 16'h0100, "R1 reset pc", new_pc, 16'h0100);
        chk(new_st == 0 && new_r0 == 0 && new_r1 == 0, "R1 reset regs", new_st | new_r0 | new_r1, 16'h0);
        chk(!busy && !mem_req, "R1 no stacking", {14'd0, busy, mem_req}, 16'd0);
        @(negedge clk);
        chk(!pc_load, "R1 single pulse", 16'(pc_load), 16'd0);

        hold_ignored(1'b0, 1'b1, 1'b1, 16'h0001, "R2 no boundary");
        hold_ignored(1'b1, 1'b1, 1'b0, 16'h00F0, "R3 masked");

        for (int i = 0; i < 8; i++) begin
            logic [15:0] pc = 16'h1000 + 16'(i) * 16'h0111;
            logic [15:0] st = 16'h0081 | (16'(i) << 4);
            logic [15:0] r0 = 16'hC000 ^ 16'(i * 37);
            logic [15:0] r1 = 16'h3000 + 16'(i * 91);
            do_entry(1'b0, 1'b1, 3'(i), pc, st, r0, r1, 3'(i));
            do_return(pc, st, r0, r1, 1'b0);
        end

        do_entry(1'b1, 1'b0, 3'd2, 16'h2222, 16'h0040, 16'h1111, 16'h3333, 3'd7);  // R4 enable off
        do_return(16'h2222, 16'h0040, 16'h1111, 16'h3333, 1'b0);
        do_entry(1'b1, 1'b1, 3'd1, 16'h2468, 16'h0001, 16'h1357, 16'h0BEE, 3'd7);  // R4 priority
        do_return(16'h2468, 16'h0001, 16'h1357, 16'h0BEE, 1'b0);

        // R11 nesting, with a colliding request on the outer return (R10)
        do_entry(1'b0, 1'b1, 3'd3, 16'hAAAA, 16'h0011, 16'h5555, 16'h7777, 3'd3);
        chk(sp_m == 16'h01F8, "R11 first frame", sp_m, 16'h01F8);
        do_entry(1'b1, 1'b0, 3'd0, 16'hBBBB, 16'h0010, 16'h6666, 16'h8888, 3'd7);
        do_return(16'hBBBB, 16'h0010, 16'h6666, 16'h8888, 1'b0);
        do_return(16'hAAAA, 16'h0011, 16'h5555, 16'h7777, 1'b1);
        chk(sp_m == 16'h0200, "R11 unwound", sp_m, 16'h0200);
        hold_ignored(1'b0, 1'b0, 1'b0, 16'h0001, "R10 request not taken after return");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule